// File: doc/BRIEF.md
# Upward-Growing Stack Address Unit with Limit Trap

This block produces the memory addresses for a word-aligned software stack that grows from low to high addresses. It keeps a 16-bit byte-addressed stack pointer that always names the first free word. A data push writes at the pointer and then adds two. A pop subtracts two and then reads at the new pointer. A call or an exception saves a 23-bit program counter as two words on two consecutive clock cycles. The second word carries the upper counter bits, with either zeros or a status byte above them. The block drives the address, write data and read/write strobes toward an external data memory. All of these outputs are registered.

Every effective address that the block produces is compared with two bounds: a programmable upper limit register and a fixed lower floor at 0x0800. If an address lies above the limit or below the floor, the block sets a sticky stack-error flag. That operation still moves the pointer, but its memory strobe is suppressed. Software clears the flag with a dedicated input. The limit register also raises a hazard flag when a stack read follows a limit write too closely.

Top module: `stack_addr_unit`

## Requirements
- R1: A synchronous active-high reset sets the pointer to 0x0800 and clears trap, busy, lim_hazard, mem_we and mem_re. The limit register keeps its value through reset.
- R2: A push places mem_addr = pointer, mem_wdata = push_data and mem_we = 1 on the outputs one clock after the request. The pointer rises by 2 in the same clock.
- R3: A pop lowers the pointer by 2 and places mem_addr = new pointer and mem_re = 1 on the outputs one clock after the request. mem_wdata is left unchanged.
- R4: An effective address greater than the limit sets trap, and an address equal to the limit does not. A limit write clears bit 0 of the stored value. The new value applies to operations from the next cycle on; an operation in the same cycle as the write uses the old limit.
- R5: An effective address below 0x0800 sets trap.
- R6: An operation that traps still updates the pointer, but it asserts neither mem_we nor mem_re. trap stays set until trap_clear is asserted. If a trapping operation and trap_clear fall in the same cycle, trap stays set.
- R7: A call writes pc_in[15:0] at the pointer, then writes {9'b0, pc_in[22:16]} at the pointer + 2 in the following cycle. busy is high in the cycle between the two writes, the pointer rises by 4 in total, and every request made while busy is high is ignored.
- R8: An exception push works like a call, except that its second word is {stat_in[7:0], 1'b0, pc_in[22:16]}.
- R9: The block performs at most one operation per cycle. When requests coincide, call wins over exception, exception over push, and push over pop.
- R10: sp_we loads the pointer with {sp_wdata[15:1], 1'b0}, but only in a cycle in which no stack operation is performed (a busy cycle counts as an operation). If an operation is performed, the load is dropped.
- R11: A pop request in the cycle right after a limit write raises lim_hazard for one cycle. A pop in the same cycle as the write does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push one data word |
| push_data | input | 16 | Word to push |
| pop_req | input | 1 | Pop one word |
| call_req | input | 1 | Two-word program-counter push, zero-extended |
| exc_req | input | 1 | Two-word program-counter push with status byte |
| pc_in | input | 23 | Program counter to save |
| stat_in | input | 8 | Status byte for exception pushes |
| lim_we | input | 1 | Write the limit register |
| lim_wdata | input | 16 | New limit value (bit 0 ignored) |
| sp_we | input | 1 | Load the stack pointer |
| sp_wdata | input | 16 | New pointer value (bit 0 ignored) |
| trap_clear | input | 1 | Clear the sticky stack-error flag |
| mem_addr | output | 16 | Memory byte address of the last operation |
| mem_wdata | output | 16 | Memory write data of the last write |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | Second word of a PC push is pending |
| trap | output | 1 | Sticky stack-error flag |
| lim_hazard | output | 1 | Pop requested right after a limit write |

## Verification
Two pairs of functions can fall in the same cycle. A trapping operation can coincide with trap_clear, and a limit write can coincide with the push that is judged against that limit. The bench drives both collisions on purpose. In the first, trap must still read one afterwards. In the second, the push must be judged against the limit that was in force before the write. A behavioural model that keeps its own pointer, limit and pending-word state predicts every output on every clock, and named checks pin down the specific expected values.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PUSH,
    OP_POP,
    OP_CALL,
    OP_EXC,
    OP_PCHI
  } stk_op_e;
endpackage

// File: rtl/stk_limit_reg.sv
module stk_limit_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lim_we,
  input  logic [AW-1:0] lim_wdata,
  input  logic          pop_req,
  output logic [AW-1:0] lim_q,
  output logic          hazard_q
);
  logic wr_seen_q;

  // limit value intentionally has no reset
  always_ff @(posedge clk) begin
    if (lim_we) lim_q <= {lim_wdata[AW-1:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen_q <= 1'b0;
      hazard_q  <= 1'b0;
    end else begin
      wr_seen_q <= lim_we;
      hazard_q  <= pop_req & wr_seen_q;
    end
  end
endmodule

// File: rtl/stk_bound_chk.sv
module stk_bound_chk #(
  parameter int AW    = 16,
  parameter int FLOOR = 'h0800
) (
  input  logic [AW-1:0] ea,
  input  logic [AW-1:0] lim,
  input  logic          active,
  output logic          err
);
  localparam logic [AW-1:0] FLOOR_V = AW'(FLOOR);

  always_comb begin
    err = active & ((ea > lim) | (ea < FLOOR_V));
  end
endmodule

// File: rtl/stk_op_sel.sv
module stk_op_sel
  import stk_pkg::*;
#(
  parameter int AW  = 16,
  parameter int HIW = 7,
  parameter int STW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_req,
  input  logic           pop_req,
  input  logic           call_req,
  input  logic           exc_req,
  input  logic [HIW-1:0] pc_hi,
  input  logic [STW-1:0] stat_in,
  output stk_op_e        op,
  output logic [AW-1:0]  hi_word,
  output logic           busy
);
  localparam int PADW  = AW - STW - HIW;
  localparam int ZPADW = AW - HIW;

  always_comb begin
    if (busy)          op = OP_PCHI;
    else if (call_req) op = OP_CALL;
    else if (exc_req)  op = OP_EXC;
    else if (push_req) op = OP_PUSH;
    else if (pop_req)  op = OP_POP;
    else               op = OP_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      hi_word <= '0;
    end else begin
      busy <= (op == OP_CALL) || (op == OP_EXC);
      if (op == OP_CALL) hi_word <= {{ZPADW{1'b0}}, pc_hi};
      else if (op == OP_EXC) hi_word <= {stat_in, {PADW{1'b0}}, pc_hi};
    end
  end
endmodule

// File: rtl/stack_addr_unit.sv
module stack_addr_unit
  import stk_pkg::*;
#(
  parameter int AW       = 16,
  parameter int PCW      = 23,
  parameter int STW      = 8,
  parameter int FLOOR    = 'h0800,
  parameter int SP_RESET = 'h0800
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_req,
  input  logic [AW-1:0]  push_data,
  input  logic           pop_req,
  input  logic           call_req,
  input  logic           exc_req,
  input  logic [PCW-1:0] pc_in,
  input  logic [STW-1:0] stat_in,
  input  logic           lim_we,
  input  logic [AW-1:0]  lim_wdata,
  input  logic           sp_we,
  input  logic [AW-1:0]  sp_wdata,
  input  logic           trap_clear,
  output logic [AW-1:0]  mem_addr,
  output logic [AW-1:0]  mem_wdata,
  output logic           mem_we,
  output logic           mem_re,
  output logic [AW-1:0]  sp,
  output logic           busy,
  output logic           trap,
  output logic           lim_hazard
);
  localparam int HIW = PCW - AW;
  localparam logic [AW-1:0] STEP = AW'(2);

  stk_op_e       op;
  logic [AW-1:0] hi_word, lim, ea, wsrc;
  logic          err, is_write;

  stk_op_sel #(.AW(AW), .HIW(HIW), .STW(STW)) u_sel (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .call_req(call_req), .exc_req(exc_req), .pc_hi(pc_in[PCW-1:AW]),
    .stat_in(stat_in), .op(op), .hi_word(hi_word), .busy(busy)
  );

  stk_limit_reg #(.AW(AW)) u_lim (
    .clk(clk), .rst(rst), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .pop_req(pop_req), .lim_q(lim), .hazard_q(lim_hazard)
  );

  stk_bound_chk #(.AW(AW), .FLOOR(FLOOR)) u_chk (
    .ea(ea), .lim(lim), .active(op != OP_NONE), .err(err)
  );

  always_comb begin
    ea       = (op == OP_POP) ? sp - STEP : sp;
    is_write = (op == OP_PUSH) || (op == OP_CALL) || (op == OP_EXC) || (op == OP_PCHI);
    case (op)
      OP_PUSH:        wsrc = push_data;
      OP_CALL, OP_EXC: wsrc = pc_in[AW-1:0];
      default:        wsrc = hi_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= AW'(SP_RESET);
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      trap      <= 1'b0;
    end else begin
      mem_we <= is_write & ~err;
      mem_re <= (op == OP_POP) & ~err;
      trap   <= err | (trap & ~trap_clear);
      if (op != OP_NONE) begin
        mem_addr <= ea;
        sp       <= (op == OP_POP) ? sp - STEP : sp + STEP;
        if (is_write) mem_wdata <= wsrc;
      end else if (sp_we) begin
        sp <= {sp_wdata[AW-1:1], 1'b0};
      end
    end
  end
endmodule

// File: rtl/stack_addr_unit_chk.sv
module stack_addr_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          push_req,
  input logic          pop_req,
  input logic          call_req,
  input logic          exc_req,
  input logic          trap_clear,
  input logic [AW-1:0] sp,
  input logic          busy,
  input logic          trap,
  input logic          mem_we,
  input logic          mem_re,
  input logic          lim_hazard
);
  logic push_go, pop_go;
  assign push_go = push_req && !busy && !call_req && !exc_req;
  assign pop_go  = pop_req && !push_req && !busy && !call_req && !exc_req;

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    push_go |=> sp == $past(sp) + AW'(2)); // R2
  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (rst)
    pop_go |=> sp == $past(sp) - AW'(2)); // R3
  AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trap && !trap_clear) |=> trap); // R6
  AST_TRAP_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(trap) |-> (!mem_we && !mem_re)); // R6
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R7
  AST_CALL_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((call_req || exc_req) && !busy) |=> busy); // R7
  AST_HAZARD_POP: assert property (@(posedge clk) disable iff (rst)
    lim_hazard |-> $past(pop_req)); // R11
endmodule

bind stack_addr_unit stack_addr_unit_chk #(.AW(AW)) u_chk_bind (
  .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
  .call_req(call_req), .exc_req(exc_req), .trap_clear(trap_clear),
  .sp(sp), .busy(busy), .trap(trap), .mem_we(mem_we), .mem_re(mem_re),
  .lim_hazard(lim_hazard)
);

// File: tb/tb_stack_addr_unit.sv
module tb_stack_addr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_req = 0, pop_req = 0, call_req = 0, exc_req = 0;
  logic [15:0] push_data = 0;
  logic [22:0] pc_in = 0;
  logic [7:0]  stat_in = 0;
  logic        lim_we = 0, sp_we = 0, trap_clear = 0;
  logic [15:0] lim_wdata = 0, sp_wdata = 0;
  logic [15:0] mem_addr, mem_wdata, sp;
  logic        mem_we, mem_re, busy, trap, lim_hazard;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  always #10 clk = ~clk;

  stack_addr_unit dut (
    .clk(clk), .rst(rst), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .call_req(call_req), .exc_req(exc_req),
    .pc_in(pc_in), .stat_in(stat_in), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .trap_clear(trap_clear),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .sp(sp), .busy(busy), .trap(trap), .lim_hazard(lim_hazard)
  );

  // behavioural reference state
  logic [15:0] m_sp, m_lim, m_addr, m_wdata, m_hi;
  logic        m_we, m_re, m_trap, m_busy, m_haz, m_lwq;

  always @(posedge clk) begin
    int op;
    logic [15:0] ea;
    logic err;
    started = 1;
    if (rst) begin
      m_sp = 16'h0800; m_addr = 0; m_wdata = 0; m_hi = 0;
      m_we = 0; m_re = 0; m_trap = 0; m_busy = 0; m_haz = 0; m_lwq = 0;
    end else begin
      m_haz = pop_req && m_lwq;
      m_lwq = lim_we;
      if (m_busy) op = 5;
      else if (call_req) op = 3;
      else if (exc_req) op = 4;
      else if (push_req) op = 1;
      else if (pop_req) op = 2;
      else op = 0;
      ea  = (op == 2) ? m_sp - 16'd2 : m_sp;
      err = (op != 0) && ((ea > m_lim) || (ea < 16'h0800));
      m_we   = (op == 1 || op == 3 || op == 4 || op == 5) && !err;
      m_re   = (op == 2) && !err;
      m_trap = err || (m_trap && !trap_clear);
      if (op == 1) m_wdata = push_data;
      if (op == 3 || op == 4) m_wdata = pc_in[15:0];
      if (op == 5) m_wdata = m_hi;
      if (op == 3) m_hi = {9'd0, pc_in[22:16]};
      if (op == 4) m_hi = {stat_in, 1'b0, pc_in[22:16]};
      m_busy = (op == 3 || op == 4);
      if (op != 0) begin
        m_addr = ea;
        m_sp = (op == 2) ? m_sp - 16'd2 : m_sp + 16'd2;
      end else if (sp_we) m_sp = sp_wdata & 16'hFFFE;
      if (lim_we) m_lim = lim_wdata & 16'hFFFE;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 sp", sp, m_sp);
      chk("R3 mem_addr", mem_addr, m_addr);
      chk("R7 mem_wdata", mem_wdata, m_wdata);
      chk("R6 mem_we", mem_we, m_we);
      chk("R3 mem_re", mem_re, m_re);
      chk("R4 trap", trap, m_trap);
      chk("R7 busy", busy, m_busy);
      chk("R11 lim_hazard", lim_hazard, m_haz);
    end
  end

  task automatic idle();
    push_req = 0; pop_req = 0; call_req = 0; exc_req = 0;
    lim_we = 0; sp_we = 0; trap_clear = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    step();
    chk("R1 reset sp", sp, 16'h0800);
    chk("R1 reset trap", trap, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset strobes", {mem_we, mem_re, lim_hazard}, 0);

    lim_we = 1; lim_wdata = 16'h0811; step();
    for (int i = 0; i < 9; i++) begin
      push_req = 1; push_data = 16'hA000 + 16'(i); step();
      chk("R2 push addr", mem_addr, 16'h0800 + 16'(2 * i));
      chk("R2 push data", mem_wdata, 16'hA000 + 16'(i));
      chk("R4 at-limit no trap", {mem_we, trap}, 2'b10);
    end
    push_req = 1; step();
    chk("R4 above limit trap", trap, 1);
    chk("R6 trapped no write", mem_we, 0);
    chk("R6 trapped sp moves", sp, 16'h0814);
    step();
    chk("R6 sticky", trap, 1);
    trap_clear = 1; push_req = 1; step();
    chk("R6 set beats clear", trap, 1);
    trap_clear = 1; step();
    chk("R6 cleared", trap, 0);

    sp_we = 1; sp_wdata = 16'h0903; push_req = 1; step();
    chk("R10 load dropped under push", sp, 16'h0818);
    sp_we = 1; sp_wdata = 16'h0803; trap_clear = 1; step();
    chk("R10 load aligned", sp, 16'h0802);

    pop_req = 1; step();
    chk("R3 pop addr", mem_addr, 16'h0800);
    chk("R3 pop sp", sp, 16'h0800);
    chk("R3 pop re", mem_re, 1);
    pop_req = 1; step();
    chk("R5 below floor trap", trap, 1);
    chk("R5 no read", mem_re, 0);
    trap_clear = 1; step();

    lim_we = 1; lim_wdata = 16'h1FFF; sp_we = 1; sp_wdata = 16'h1FFC; step();
    lim_we = 1; lim_wdata = 16'h0900; push_req = 1; step();
    chk("R4 old limit same cycle", {trap, mem_we}, 2'b01);
    lim_we = 1; lim_wdata = 16'h1FFE; sp_we = 1; sp_wdata = 16'h1FFC; step();
    sp_we = 1; sp_wdata = 16'h1FFC; step();
    call_req = 1; push_req = 1; pc_in = 23'h5ABCDE; push_data = 16'h1111; step();
    chk("R9 call beats push", mem_wdata, 16'hBCDE);
    chk("R7 busy after first word", busy, 1);
    push_req = 1; pop_req = 1; step();
    chk("R7 second word", mem_wdata, 16'h005A);
    chk("R7 second addr", mem_addr, 16'h1FFE);
    chk("R7 sp plus 4", sp, 16'h2000);
    chk("R7 no trap at limit", trap, 0);

    lim_we = 1; lim_wdata = 16'h3000; step();
    exc_req = 1; push_req = 1; pc_in = 23'h7F1234; stat_in = 8'hC3; step();
    chk("R9 exc beats push", mem_wdata, 16'h1234);
    step();
    chk("R8 status word", mem_wdata, 16'hC37F);
    chk("R8 sp", sp, 16'h2004);
    call_req = 1; exc_req = 1; pc_in = 23'h012345; step(); step();
    chk("R9 call beats exc", mem_wdata, 16'h0001);
    push_req = 1; pop_req = 1; push_data = 16'h7777; step();
    chk("R9 push beats pop", {mem_we, mem_wdata}, {1'b1, 16'h7777});

    lim_we = 1; lim_wdata = 16'h3000; pop_req = 1; step();
    chk("R11 pop same cycle no hazard", lim_hazard, 0);
    lim_we = 1; lim_wdata = 16'h3000; step();
    pop_req = 1; step();
    chk("R11 hazard", lim_hazard, 1);
    step();
    chk("R11 hazard pulse", lim_hazard, 0);

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      push_req   = (r < 30);
      pop_req    = (r >= 20 && r < 55);
      call_req   = (r >= 55 && r < 62);
      exc_req    = (r >= 60 && r < 67);
      push_data  = 16'($urandom);
      pc_in      = 23'($urandom);
      stat_in    = 8'($urandom);
      lim_we     = ($urandom_range(0, 9) == 0);
      lim_wdata  = 16'($urandom_range(16'h0780, 16'h0A00));
      sp_we      = ($urandom_range(0, 7) == 0);
      sp_wdata   = 16'($urandom_range(16'h07F0, 16'h0A00));
      trap_clear = ($urandom_range(0, 5) == 0);
      step();
    end
    step();
    finish_run();
  end
endmodule